// File: doc/BRIEF.md
# Two-Write Two-Read Memory with Last-Writer Table

This block gives two fully independent ports, A and B, each able to write one word and read one word in every clock cycle, at any addresses. It is built only from simple memories that take one write and one read per cycle. There are four such memories. Each port copies every word it writes into its own pair of memories, so that each reading port has a copy it can read.

A one-bit flag per word, kept in flip-flops, records which port wrote that word most recently. A read fetches the word from both candidate copies and picks one of them with that flag. The flag is captured in the same clock edge as the read address, so the select lines up with the registered read data one cycle later.

Reads have a fixed latency of one cycle and cannot be stalled, so there is no back-pressure: a read request is always accepted, and its data is presented on the following cycle whether or not the consumer is ready. Between reads the read data output keeps its last value.

Top module: `lvt_twin_ram`

## Requirements
- R1: After reset both read-valid outputs are low and every last-writer flag is 0, meaning port A's copy is selected.
- R2: A read request in one cycle raises that port's read-valid in the next cycle and returns the data there; with no request, read-valid is low in the next cycle.
- R3: A word written by port A is returned by reads on either port issued in any later cycle, and that address's flag is 0 in the cycle after the write.
- R4: A word written by port B is returned by reads on either port issued in any later cycle, and that address's flag is 1 in the cycle after the write, unless port A wrote the same address in the same cycle.
- R5: Writes by both ports to different addresses in the same cycle are both kept.
- R6: When both ports write the same address in the same cycle, port A's data is kept and port B's is lost.
- R7: Across cycles, the latest write to an address wins, whichever port made it.
- R8: A read issued in the same cycle as a write to the same address returns the content from before that write.
- R9: A cycle with write enable low leaves the memory unchanged, whatever the write address and data are.
- R10: A port's read data output holds its value through cycles with no read request on that port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_we | input | 1 | Port A write enable |
| a_waddr | input | ADDR_W | Port A write address |
| a_wdata | input | DATA_W | Port A write data |
| a_re | input | 1 | Port A read request |
| a_raddr | input | ADDR_W | Port A read address |
| a_rdata | output | DATA_W | Port A read data, valid one cycle after the request |
| a_rvalid | output | 1 | Port A read data valid |
| b_we | input | 1 | Port B write enable |
| b_waddr | input | ADDR_W | Port B write address |
| b_wdata | input | DATA_W | Port B write data |
| b_re | input | 1 | Port B read request |
| b_raddr | input | ADDR_W | Port B read address |
| b_rdata | output | DATA_W | Port B read data, valid one cycle after the request |
| b_rvalid | output | 1 | Port B read data valid |

## Verification
The assertions rely on the enables and write addresses being known, never X, in every cycle after reset is released. This matters most for the flag checks, which index the flag table with the write address captured in the previous cycle. The bench meets this by driving every input to a defined value from time zero, and by changing inputs only on the falling clock edge. It compares read data only for addresses it has already written, because the memory contents are not reset.

// File: rtl/lvt_twin_pkg.sv
package lvt_twin_pkg;

  typedef enum logic {
    PORT_A = 1'b0,
    PORT_B = 1'b1
  } port_e;

  // Port whose writes feed storage bank idx: banks 0,1 take A, banks 2,3 take B.
  function automatic port_e bank_writer(input int idx);
    return (idx < 2) ? PORT_A : PORT_B;
  endfunction

  // Port served by the read side of bank idx: even banks serve A, odd banks B.
  function automatic port_e bank_reader(input int idx);
    return (idx % 2 == 0) ? PORT_A : PORT_B;
  endfunction

endpackage

// File: rtl/lvt_sdp_bank.sv
// Behavioural one-write one-read synchronous memory; read returns old data on a
// same-address collision.
module lvt_sdp_bank #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= store[raddr];
  end
endmodule

// File: rtl/lvt_flag_table.sv
// Last-writer table: one flip-flop per word, two writes and two reads per cycle.
module lvt_flag_table #(
  parameter int ADDR_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   a_we,
  input  logic [ADDR_W-1:0]      a_waddr,
  input  logic                   b_we,
  input  logic [ADDR_W-1:0]      b_waddr,
  input  logic                   a_re,
  input  logic [ADDR_W-1:0]      a_raddr,
  input  logic                   b_re,
  input  logic [ADDR_W-1:0]      b_raddr,
  output lvt_twin_pkg::port_e    a_sel,
  output lvt_twin_pkg::port_e    b_sel,
  output logic [(1<<ADDR_W)-1:0] flags
);
  import lvt_twin_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  flags[g] <= PORT_A;
      else if (a_we && a_waddr == ADDR_W'(g))      flags[g] <= PORT_A;
      else if (b_we && b_waddr == ADDR_W'(g))      flags[g] <= PORT_B;
    end
  end

  // Select captured with the read address so it lines up with bank output.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sel <= PORT_A;
      b_sel <= PORT_A;
    end else begin
      if (a_re) a_sel <= port_e'(flags[a_raddr]);
      if (b_re) b_sel <= port_e'(flags[b_raddr]);
    end
  end
endmodule

// File: rtl/lvt_twin_ram.sv
module lvt_twin_ram #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_waddr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_re,
  input  logic [ADDR_W-1:0] a_raddr,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_waddr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_re,
  input  logic [ADDR_W-1:0] b_raddr,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid
);
  import lvt_twin_pkg::*;
  localparam int NBANK = 4;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] bank_q [NBANK];
  port_e             a_sel, b_sel;
  logic [DEPTH-1:0]  flag_vec;

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    localparam port_e WR = bank_writer(i);
    localparam port_e RD = bank_reader(i);
    lvt_sdp_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk   (clk),
      .we    ((WR == PORT_A) ? a_we    : b_we),
      .waddr ((WR == PORT_A) ? a_waddr : b_waddr),
      .wdata ((WR == PORT_A) ? a_wdata : b_wdata),
      .re    ((RD == PORT_A) ? a_re    : b_re),
      .raddr ((RD == PORT_A) ? a_raddr : b_raddr),
      .q     (bank_q[i])
    );
  end

  lvt_flag_table #(.ADDR_W(ADDR_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_we    (a_we),
    .a_waddr (a_waddr),
    .b_we    (b_we),
    .b_waddr (b_waddr),
    .a_re    (a_re),
    .a_raddr (a_raddr),
    .b_re    (b_re),
    .b_raddr (b_raddr),
    .a_sel   (a_sel),
    .b_sel   (b_sel),
    .flags   (flag_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rvalid <= 1'b0;
      b_rvalid <= 1'b0;
    end else begin
      a_rvalid <= a_re;
      b_rvalid <= b_re;
    end
  end

  // Bank 0 / 2 hold A- and B-written copies for port A; bank 1 / 3 for port B.
  assign a_rdata = (a_sel == PORT_B) ? bank_q[2] : bank_q[0];
  assign b_rdata = (b_sel == PORT_B) ? bank_q[3] : bank_q[1];
endmodule

// File: rtl/lvt_twin_ram_chk.sv
module lvt_twin_ram_chk #(
  parameter int ADDR_W = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   a_we,
  input logic [ADDR_W-1:0]      a_waddr,
  input logic                   b_we,
  input logic [ADDR_W-1:0]      b_waddr,
  input logic                   a_re,
  input logic                   b_re,
  input logic                   a_rvalid,
  input logic                   b_rvalid,
  input logic [(1<<ADDR_W)-1:0] flag_vec
);
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!a_rvalid && !b_rvalid && flag_vec == '0);
    end
  end

  assert_a_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    a_re |=> a_rvalid);
  assert_b_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    b_re |=> b_rvalid);
  assert_a_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !a_re |=> !a_rvalid);
  assert_b_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !b_re |=> !b_rvalid);
  assert_a_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    a_we |=> (flag_vec[$past(a_waddr)] == 1'b0));
  assert_b_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (b_we && !(a_we && a_waddr == b_waddr)) |=> (flag_vec[$past(b_waddr)] == 1'b1));
  assert_collision_a_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && b_we && a_waddr == b_waddr) |=> (flag_vec[$past(b_waddr)] == 1'b0));
endmodule

bind lvt_twin_ram lvt_twin_ram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .a_we     (a_we),
  .a_waddr  (a_waddr),
  .b_we     (b_we),
  .b_waddr  (b_waddr),
  .a_re     (a_re),
  .b_re     (b_re),
  .a_rvalid (a_rvalid),
  .b_rvalid (b_rvalid),
  .flag_vec (flag_vec)
);

// File: tb/test_lvt_twin_ram.sv
`timescale 1ns/1ps
module test_lvt_twin_ram;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_we = 0, b_we = 0, a_re = 0, b_re = 0;
  logic [AW-1:0] a_waddr = '0, b_waddr = '0, a_raddr = '0, b_raddr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_rvalid, b_rvalid;

  int checks = 0;
  int fails = 0;

  logic [DW-1:0] model [DEPTH];
  bit            known [DEPTH];
  logic [DW-1:0] last_a, last_b;
  bit            last_a_ok = 0, last_b_ok = 0;

  always #5 clk = ~clk;

  lvt_twin_ram #(.ADDR_W(AW), .DATA_W(DW)) i_lvt_twin_ram (
    .clk(clk), .rst_n(rst_n),
    .a_we(a_we), .a_waddr(a_waddr), .a_wdata(a_wdata),
    .a_re(a_re), .a_raddr(a_raddr), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_we(b_we), .b_waddr(b_waddr), .b_wdata(b_wdata),
    .b_re(b_re), .b_raddr(b_raddr), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive at falling edge, apply, compare at the next falling edge.
  task automatic step(input string req,
                      input logic awe, input logic [AW-1:0] awa, input logic [DW-1:0] awd,
                      input logic are, input logic [AW-1:0] ara,
                      input logic bwe, input logic [AW-1:0] bwa, input logic [DW-1:0] bwd,
                      input logic bre, input logic [AW-1:0] bra);
    logic [DW-1:0] ea, eb;
    bit oka, okb;
    ea = model[ara]; oka = known[ara];
    eb = model[bra]; okb = known[bra];
    a_we = awe; a_waddr = awa; a_wdata = awd; a_re = are; a_raddr = ara;
    b_we = bwe; b_waddr = bwa; b_wdata = bwd; b_re = bre; b_raddr = bra;
    @(negedge clk);
    check({req, " a_rvalid (R2)"}, {15'd0, a_rvalid}, {15'd0, are});
    check({req, " b_rvalid (R2)"}, {15'd0, b_rvalid}, {15'd0, bre});
    if (are) begin
      if (oka) check({req, " a_rdata"}, a_rdata, ea);
      last_a = ea; last_a_ok = oka;
    end else if (last_a_ok) check({req, " a_rdata hold (R10)"}, a_rdata, last_a);
    if (bre) begin
      if (okb) check({req, " b_rdata"}, b_rdata, eb);
      last_b = eb; last_b_ok = okb;
    end else if (last_b_ok) check({req, " b_rdata hold (R10)"}, b_rdata, last_b);
    if (bwe) begin model[bwa] = bwd; known[bwa] = 1; end
    if (awe) begin model[awa] = awd; known[awa] = 1; end
  endtask

  task automatic idle_reads(input string req, input logic [AW-1:0] ra, input logic [AW-1:0] rb);
    step(req, 0, 0, 0, 1, ra, 0, 0, 0, 1, rb);
  endtask

  task automatic t_reset_R1;
    checks++;
    if (a_rvalid !== 1'b0 || b_rvalid !== 1'b0) begin
      fails++;
      $display("FAIL R1 rvalid actual=%b%b expected=00", a_rvalid, b_rvalid);
    end
  endtask

  task automatic t_port_a_R3;
    step("R3 write", 1, 5'd3, 16'hA003, 0, 0, 0, 0, 0, 0, 0);
    idle_reads("R3 read both", 5'd3, 5'd3);
  endtask

  task automatic t_port_b_R4;
    step("R4 write", 0, 0, 0, 0, 0, 1, 5'd9, 16'hB009, 0, 0);
    idle_reads("R4 read both", 5'd9, 5'd9);
  endtask

  task automatic t_dual_R5;
    step("R5 dual write", 1, 5'd1, 16'h1111, 0, 0, 1, 5'd30, 16'h3030, 0, 0);
    idle_reads("R5 read", 5'd30, 5'd1);
    idle_reads("R5 read swap", 5'd1, 5'd30);
  endtask

  task automatic t_collision_R6;
    step("R6 collide", 1, 5'd12, 16'hAAAA, 0, 0, 1, 5'd12, 16'hBBBB, 0, 0);
    idle_reads("R6 A wins", 5'd12, 5'd12);
  endtask

  task automatic t_last_wins_R7;
    step("R7 A first", 1, 5'd20, 16'h2001, 0, 0, 0, 0, 0, 0, 0);
    step("R7 B later", 0, 0, 0, 0, 0, 1, 5'd20, 16'h2002, 0, 0);
    idle_reads("R7 B holds", 5'd20, 5'd20);
    step("R7 A again", 1, 5'd20, 16'h2003, 0, 0, 0, 0, 0, 0, 0);
    idle_reads("R7 A holds", 5'd20, 5'd20);
  endtask

  task automatic t_rdw_R8;
    step("R8 read old", 1, 5'd3, 16'hC003, 1, 5'd3, 1, 5'd9, 16'hC009, 1, 5'd9);
    idle_reads("R8 new visible", 5'd9, 5'd3);
  endtask

  task automatic t_we_low_R9;
    a_wdata = 16'hDEAD;
    step("R9 no write", 0, 5'd1, 16'hDEAD, 0, 0, 0, 5'd30, 16'hBEEF, 0, 0);
    idle_reads("R9 unchanged", 5'd1, 5'd30);
  endtask

  task automatic t_hold_R10;
    idle_reads("R10 prime", 5'd12, 5'd20);
    step("R10 hold+write", 1, 5'd12, 16'h5555, 0, 0, 1, 5'd20, 16'h6666, 0, 0);
    step("R10 hold", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_stream_mix;
    for (int k = 0; k < 40; k++) begin
      step("R7 stream", 1, AW'(k), DW'(k * 7 + 1), 1, AW'(k + 5),
           (k % 3) != 0, AW'(k + 2), DW'(k * 13 + 2), 1, AW'(k + 1));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin model[i] = '0; known[i] = 0; end
    repeat (2) @(negedge clk);
    t_reset_R1();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R1();
    t_port_a_R3();
    t_port_b_R4();
    t_dual_R5();
    t_collision_R6();
    t_last_wins_R7();
    t_rdw_R8();
    t_we_low_R9();
    t_hold_R10();
    t_stream_mix();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule